// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block handles low-power entry and exit for a small microcontroller core. When the core raises a halt request, the block drops the system clock enable and the core stops at the halt. The block itself runs on a free-running, always-on clock. While the core sleeps, the block watches four wake sources: an external reset request, a watchdog overflow, a pending interrupt, and a falling edge on any 8-bit port pin whose wake-enable bit is set.

When the core wakes, the block reports the kind of wake with a one-cycle pulse: full reset, watchdog reset, resume after the halt, or interrupt wake. The core's reset logic uses that pulse to decide how much state to clear. The block also keeps two status flags. The power-down flag is set on entry to sleep. The time-out flag is set by a watchdog overflow. Together the two flags encode the wake cause for software.

The block drives the watchdog clear strobe and the watchdog run enable. During sleep the watchdog keeps running only if it is enabled and clocked from the slow subsidiary clock.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: With the clock enable high and no external reset or watchdog overflow, a halt request takes effect at the next edge. After that edge `sys_clk_en_o` is 0, `pdf_o` is 1, `to_o` is 0, and `wdt_clr_o` pulses for one cycle. A halt request is ignored while the clock enable is low.
- R2: A watchdog-clear command while running, with no halt in the same cycle, clears `pdf_o` and pulses `wdt_clr_o` at the next edge.
- R3: `wdt_run_o` equals `wdt_en_i` while running. While the clock enable is low it equals `wdt_en_i & wdt_src_slow_i`, where `wdt_src_slow_i`=1 selects the slow subsidiary clock.
- R4: At most one of the four wake-kind pulses is high in any cycle.
- R5: If sources arrive together while asleep, the block reports only the highest one. The order is external reset, then watchdog overflow, then interrupt, then port edge.
- R6: An external reset request, in any state, gives a `full_reset_o` pulse at the next edge and clears both `pdf_o` and `to_o`.
- R7: A watchdog overflow without an external reset gives a `wdt_reset_o` pulse at the next edge and sets `to_o`. `pdf_o` keeps its value.
- R8: While asleep, a high-to-low transition on a port pin whose bit in `wake_en_i` is 1 gives a `resume_o` pulse 3 edges after the pin changes, with both flags unchanged. Falling edges on disabled pins, rising edges, and edges seen while running have no effect.
- R9: A pending interrupt while asleep gives an `irq_wake_o` pulse at the next edge, with the flags unchanged. An interrupt while running gives no pulse.
- R10: Every wake from sleep raises `sys_clk_en_o` on the edge after its pulse. At that edge `resume_o` and `irq_wake_o` are 0.
- R11: After reset, `sys_clk_en_o` is 1, both flags are 0, and all pulses and `wdt_clr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on free-running clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| halt_req_i | input | 1 | Halt request from the core |
| wdt_clr_i | input | 1 | Watchdog-clear command from the core |
| ext_rst_i | input | 1 | Synchronised external reset request |
| irq_pend_i | input | 1 | System interrupt pending |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| port_i | input | 8 | Asynchronous port pin levels |
| wake_en_i | input | 8 | Per-pin falling-edge wake enable |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_src_slow_i | input | 1 | Watchdog clocked by the slow subsidiary clock |
| sys_clk_en_o | output | 1 | System clock enable |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Time-out flag |
| full_reset_o | output | 1 | Wake kind: full system reset |
| wdt_reset_o | output | 1 | Wake kind: PC and stack pointer reset only |
| resume_o | output | 1 | Wake kind: resume after the halt |
| irq_wake_o | output | 1 | Wake kind: interrupt wake |
| wdt_clr_o | output | 1 | Watchdog count clear strobe |
| wdt_run_o | output | 1 | Watchdog run enable |

## Verification
Halt, watchdog-clear, external reset, overflow and interrupt inputs take effect at the first edge after they are driven. The bench drives them for exactly one edge and reads the pulses and flags just after that edge. A port edge has to cross two synchroniser flops and the edge register, so the bench checks that nothing has fired after two edges and that `resume_o` is high after the third. The clock enable is checked one edge after each wake pulse, together with the fall of that pulse.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_WAKE
  } swc_state_e;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_FULL,
    WK_WDT,
    WK_IRQ,
    WK_PIN
  } wake_kind_e;
endpackage

// File: rtl/swc_pin_sync.sv
module swc_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] fall_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its one-cycle-old copy
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '1;
      else         sh <= {sh[STAGES-1:0], pin_i[g]};
    end
    assign fall_o[g] = sh[STAGES] & ~sh[STAGES-1];
  end
endmodule

// File: rtl/swc_wake_arb.sv
module swc_wake_arb
  import swc_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  swc_state_e       state_i,
  input  logic             ext_rst_i,
  input  logic             wdt_ovf_i,
  input  logic             irq_i,
  input  logic [WIDTH-1:0] fall_i,
  input  logic [WIDTH-1:0] wake_en_i,
  output wake_kind_e       kind_o
);
  logic asleep;
  logic pin_hit;

  assign asleep  = (state_i == ST_SLEEP);
  assign pin_hit = |(fall_i & wake_en_i);

  always_comb begin
    if (ext_rst_i)            kind_o = WK_FULL;
    else if (wdt_ovf_i)       kind_o = WK_WDT;
    else if (asleep && irq_i) kind_o = WK_IRQ;
    else if (asleep && pin_hit) kind_o = WK_PIN;
    else                      kind_o = WK_NONE;
  end
endmodule

// File: rtl/swc_flags.sv
module swc_flags
  import swc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wake_kind_e kind_i,
  input  logic       enter_sleep_i,
  input  logic       clr_cmd_i,
  output logic       pdf_o,
  output logic       to_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdf_o <= 1'b0;
      to_o  <= 1'b0;
    end else if (kind_i == WK_FULL) begin
      pdf_o <= 1'b0;
      to_o  <= 1'b0;
    end else if (kind_i == WK_WDT) begin
      to_o  <= 1'b1;
    end else if (enter_sleep_i) begin
      pdf_o <= 1'b1;
      to_o  <= 1'b0;
    end else if (clr_cmd_i) begin
      pdf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_req_i,
  input  logic              wdt_clr_i,
  input  logic              ext_rst_i,
  input  logic              irq_pend_i,
  input  logic              wdt_ovf_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [PORT_W-1:0] wake_en_i,
  input  logic              wdt_en_i,
  input  logic              wdt_src_slow_i,
  output logic              sys_clk_en_o,
  output logic              pdf_o,
  output logic              to_o,
  output logic              full_reset_o,
  output logic              wdt_reset_o,
  output logic              resume_o,
  output logic              irq_wake_o,
  output logic              wdt_clr_o,
  output logic              wdt_run_o
);
  swc_state_e        state_q, state_d;
  wake_kind_e        kind;
  logic [PORT_W-1:0] fall;
  logic              running;
  logic              enter_sleep;
  logic              clr_cmd;

  swc_pin_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (port_i),
    .fall_o (fall)
  );

  swc_wake_arb #(.WIDTH(PORT_W)) u_arb (
    .state_i   (state_q),
    .ext_rst_i (ext_rst_i),
    .wdt_ovf_i (wdt_ovf_i),
    .irq_i     (irq_pend_i),
    .fall_i    (fall),
    .wake_en_i (wake_en_i),
    .kind_o    (kind)
  );

  assign running     = (state_q == ST_RUN);
  assign enter_sleep = running && halt_req_i && (kind == WK_NONE);
  assign clr_cmd     = running && wdt_clr_i;

  swc_flags u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .kind_i        (kind),
    .enter_sleep_i (enter_sleep),
    .clr_cmd_i     (clr_cmd),
    .pdf_o         (pdf_o),
    .to_o          (to_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (enter_sleep) state_d = ST_SLEEP;
      ST_SLEEP: if (kind != WK_NONE) state_d = ST_WAKE;
      ST_WAKE:  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RUN;
      full_reset_o <= 1'b0;
      wdt_reset_o  <= 1'b0;
      resume_o     <= 1'b0;
      irq_wake_o   <= 1'b0;
      wdt_clr_o    <= 1'b0;
    end else begin
      state_q      <= state_d;
      full_reset_o <= (kind == WK_FULL);
      wdt_reset_o  <= (kind == WK_WDT);
      resume_o     <= (kind == WK_PIN);
      irq_wake_o   <= (kind == WK_IRQ);
      wdt_clr_o    <= enter_sleep || clr_cmd;
    end
  end

  assign sys_clk_en_o = running;
  // system-clocked watchdog freezes while the core clock is gated
  assign wdt_run_o    = running ? wdt_en_i : (wdt_en_i & wdt_src_slow_i);
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int unsigned PORT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_req_i,
  input logic              wdt_clr_i,
  input logic              ext_rst_i,
  input logic              irq_pend_i,
  input logic              wdt_ovf_i,
  input logic [PORT_W-1:0] port_i,
  input logic [PORT_W-1:0] wake_en_i,
  input logic              wdt_en_i,
  input logic              wdt_src_slow_i,
  input logic              sys_clk_en_o,
  input logic              pdf_o,
  input logic              to_o,
  input logic              full_reset_o,
  input logic              wdt_reset_o,
  input logic              resume_o,
  input logic              irq_wake_o,
  input logic              wdt_clr_o,
  input logic              wdt_run_o
);
  logic [3:0] pulses;
  logic       any_pulse;
  logic       asleep;
  logic       unused_ok;

  assign pulses    = {full_reset_o, wdt_reset_o, resume_o, irq_wake_o};
  assign any_pulse = |pulses;
  assign asleep    = !sys_clk_en_o && !any_pulse;
  assign unused_ok = ^{port_i, wake_en_i};

  assert_halt_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_clk_en_o && halt_req_i && !ext_rst_i && !wdt_ovf_i
    |=> !sys_clk_en_o && pdf_o && !to_o && wdt_clr_o);

  assert_clr_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_clk_en_o && wdt_clr_i && !halt_req_i && !ext_rst_i && !wdt_ovf_i
    |=> !pdf_o && wdt_clr_o);

  assert_wdt_run_sleep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_clk_en_o |-> (wdt_run_o == (wdt_en_i && wdt_src_slow_i)));

  assert_one_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pulses));

  assert_ext_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> full_reset_o && !pdf_o && !to_o);

  assert_wdt_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_ovf_i && !ext_rst_i |=> wdt_reset_o && to_o && (pdf_o == $past(pdf_o)));

  assert_irq_sleep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep && irq_pend_i && !ext_rst_i && !wdt_ovf_i |=> irq_wake_o);

  assert_no_wake_running_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_clk_en_o |=> !irq_wake_o && !resume_o);

  assert_clk_back_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_clk_en_o && any_pulse |=> sys_clk_en_o && !resume_o && !irq_wake_o);
endmodule

bind sleep_wake_ctrl swc_checker #(.PORT_W(PORT_W)) u_chk (.*);

// File: tb/sim_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_wake_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       halt_req_i = 1'b0, wdt_clr_i = 1'b0, ext_rst_i = 1'b0;
  logic       irq_pend_i = 1'b0, wdt_ovf_i = 1'b0;
  logic [7:0] port_i = 8'hFF, wake_en_i = 8'h00;
  logic       wdt_en_i = 1'b0, wdt_src_slow_i = 1'b0;
  logic       sys_clk_en_o, pdf_o, to_o, full_reset_o, wdt_reset_o;
  logic       resume_o, irq_wake_o, wdt_clr_o, wdt_run_o;

  int checks = 0, errors = 0;
  logic exp_pdf = 1'b0, exp_to = 1'b0;
  logic done = 1'b0;

  always #2 clk_i = ~clk_i;

  sleep_wake_ctrl u0 (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pulses();
    return {full_reset_o, wdt_reset_o, resume_o, irq_wake_o};
  endfunction

  // priority model: {full, wdt, resume, irq}
  function automatic logic [3:0] exp_kind(logic e, logic o, logic i, logic p);
    if (e) return 4'b1000;
    if (o) return 4'b0100;
    if (i) return 4'b0001;
    if (p) return 4'b0010;
    return 4'b0000;
  endfunction

  function automatic void apply_flags(logic [3:0] k);
    if (k[3]) begin exp_pdf = 1'b0; exp_to = 1'b0; end
    else if (k[2]) exp_to = 1'b1;
  endfunction

  task automatic check_flags(string req);
    check({req, " pdf"}, pdf_o, exp_pdf);
    check({req, " to"}, to_o, exp_to);
  endtask

  task automatic do_halt(logic en, logic slow);
    wdt_en_i = en; wdt_src_slow_i = slow;
    halt_req_i = 1'b1;
    tick();
    halt_req_i = 1'b0;
    exp_pdf = 1'b1; exp_to = 1'b0;
    check("R1 clk_en", sys_clk_en_o, 1'b0);
    check("R1 wdt_clr", wdt_clr_o, 1'b1);
    check_flags("R1");
    check("R3 wdt_run sleep", wdt_run_o, en & slow);
  endtask

  task automatic after_wake();
    tick();
    check("R10 clk_en", sys_clk_en_o, 1'b1);
    check("R10 pulses", pulses(), 4'b0000);
    check("R3 wdt_run run", wdt_run_o, wdt_en_i);
  endtask

  task automatic pulse_src(logic e, logic o, logic i);
    ext_rst_i = e; wdt_ovf_i = o; irq_pend_i = i;
    tick();
    ext_rst_i = 1'b0; wdt_ovf_i = 1'b0; irq_pend_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] k;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    // R11 reset state
    check("R11 clk_en", sys_clk_en_o, 1'b1);
    check("R11 pdf", pdf_o, 1'b0);
    check("R11 to", to_o, 1'b0);
    check("R11 pulses", pulses(), 4'b0000);
    check("R11 wdt_clr", wdt_clr_o, 1'b0);

    // R9 interrupt while running ignored
    pulse_src(1'b0, 1'b0, 1'b1);
    check("R9 run irq", pulses(), 4'b0000);
    check("R9 run clk_en", sys_clk_en_o, 1'b1);

    // R8 enabled pin falling while running ignored
    wake_en_i = 8'h01; port_i = 8'hFE;
    repeat (4) begin
      tick();
      check("R8 run edge", resume_o, 1'b0);
    end
    port_i = 8'hFF;
    repeat (3) tick();

    // R1 halt wins over same-cycle clear command
    wdt_clr_i = 1'b1;
    do_halt(1'b1, 1'b0);
    wdt_clr_i = 1'b0;
    // R1 halt ignored while asleep
    halt_req_i = 1'b1; tick(); halt_req_i = 1'b0;
    check("R1 halt asleep", sys_clk_en_o, 1'b0);
    check("R1 halt asleep clr", wdt_clr_o, 1'b0);
    pulse_src(1'b0, 1'b0, 1'b1);
    check("R9 sleep irq", pulses(), 4'b0001);
    check_flags("R9");
    after_wake();

    // R2 clear command while running
    wdt_clr_i = 1'b1; tick(); wdt_clr_i = 1'b0;
    exp_pdf = 1'b0;
    check("R2 pdf", pdf_o, 1'b0);
    check("R2 wdt_clr", wdt_clr_o, 1'b1);

    // R6 external reset while running
    wdt_ovf_i = 1'b1; tick(); wdt_ovf_i = 1'b0;
    exp_to = 1'b1;
    check("R7 run ovf", wdt_reset_o, 1'b1);
    check_flags("R7 run");
    pulse_src(1'b1, 1'b0, 1'b0);
    exp_pdf = 1'b0; exp_to = 1'b0;
    check("R6 run ext", full_reset_o, 1'b1);
    check_flags("R6 run");
    tick();

    // R8 rising edge and disabled pin while asleep ignored
    port_i = 8'hFD; wake_en_i = 8'h02;
    repeat (3) tick();
    do_halt(1'b1, 1'b1);
    port_i = 8'hFF;
    repeat (4) begin
      tick();
      check("R8 rising", sys_clk_en_o, 1'b0);
    end
    port_i = 8'hFE;
    repeat (4) begin
      tick();
      check("R8 disabled pin", sys_clk_en_o, 1'b0);
    end
    // R7 overflow wake keeps pdf
    pulse_src(1'b0, 1'b1, 1'b0);
    exp_to = 1'b1;
    check("R7 sleep ovf", pulses(), 4'b0100);
    check_flags("R7 sleep");
    after_wake();
    port_i = 8'hFF;
    repeat (3) tick();

    // R5 all sources together
    wake_en_i = 8'h80;
    do_halt(1'b0, 1'b1);
    port_i = 8'h7F;
    pulse_src(1'b1, 1'b1, 1'b1);
    check("R5 all", pulses(), 4'b1000);
    exp_pdf = 1'b0; exp_to = 1'b0;
    check_flags("R6 sleep");
    after_wake();
    port_i = 8'hFF;
    repeat (3) tick();

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic e, o, i;
      int pin;
      do_halt(1'($urandom), 1'($urandom));
      repeat (1 + $urandom % 3) begin
        tick();
        check("R8 idle asleep", sys_clk_en_o, 1'b0);
      end
      if ($urandom % 2) begin
        e = ($urandom % 4) == 0;
        o = ($urandom % 3) == 0;
        i = 1'b1;
        if ($urandom % 2) i = (o | e) ? 1'($urandom) : 1'b1;
        pulse_src(e, o, i);
        k = exp_kind(e, o, i, 1'b0);
        check("R5 random", pulses(), k);
        apply_flags(k);
        check_flags("R5 random");
        after_wake();
      end else begin
        pin = $urandom % 8;
        wake_en_i = 8'($urandom);
        port_i = ~(8'h01 << pin);
        tick(); tick();
        check("R8 latency", pulses(), 4'b0000);
        tick();
        k = exp_kind(1'b0, 1'b0, 1'b0, wake_en_i[pin]);
        check("R8 pin wake", pulses(), k);
        if (k != 4'b0000) begin
          check_flags("R8");
          after_wake();
        end else begin
          check("R8 disabled", sys_clk_en_o, 1'b0);
          pulse_src(1'b0, 1'b0, 1'b1);
          check("R9 fallback", pulses(), 4'b0001);
          after_wake();
        end
        port_i = 8'hFF;
        repeat (3) tick();
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule